// File: doc/BRIEF.md
# I2C Channel-Select Control Slave

This block is the digital control side of a four-way I2C bus switch. It sits on a system clock that runs well above the bus rate. SCL and SDA pass through synchronisers, and the block watches the synchronised lines for START and STOP conditions. It answers one 7-bit address: the upper four bits are fixed at 4'b1110, and three strap pins set the lower three bits. It acknowledges its address and every byte written to it.

A write stores a channel selection. The selection drives four one-hot channel-enable outputs, which model which downstream pair would be connected. The new selection only reaches the enables at the next STOP condition, so the downstream lines are idle-high when a pair is switched in.

A read returns a status byte. The upper nibble holds the live state of four active-low interrupt inputs. The low bits hold the stored selection.

Top module: `chansel_ctl`

## Requirements
- R1: Bit 2 of a written control byte enables a selection, and bits 1:0 pick the channel k, which sets chan_en[k]. When bit 2 is 0, chan_en is 4'b0000 whatever bits 1:0 hold. Bits 7:3 have no effect.
- R2: At most one bit of chan_en is 1 at any time.
- R3: chan_en does not change until the cycle after a STOP condition has been detected. It does not change when a byte is written and acknowledged.
- R4: If several data bytes are written between START and STOP, only the last complete byte takes effect at the STOP.
- R5: The address byte is {4'b1110, addr_pins[2:0], rw}, sent MSB first. rw=1 means read and rw=0 means write. On a match, the block pulls SDA low (sda_oe=1) for the ninth clock.
- R6: After reset the stored selection is 0, chan_en is 4'b0000 and sda_oe is 0.
- R7: On a read the block shifts out {~irq_n[3:0], 1'b0, sel[2:0]} MSB first. Bit 7 maps to channel 3 and bit 4 to channel 0. The interrupt state is sampled when the byte is loaded.
- R8: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Either one in the middle of a byte aborts that byte, and the partial byte has no effect.
- R9: A non-matching address gets no ACK. Until the next START the block then drives nothing and ignores written bytes.
- R10: After a read byte, a master ACK makes the block send a freshly sampled status byte. A master NACK ends the read, and SDA stays released.
- R11: Every data byte of a write to the block's address is acknowledged by pulling SDA low for the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| addr_pins | input | 3 | Strap pins giving address bits 2:0 |
| irq_n | input | 4 | Active-low interrupt inputs, one per channel |
| chan_en | output | 4 | One-hot enable of the connected downstream pair |

## Verification
A corrupted stored selection shows on chan_en right after the STOP that commits it. It shows again in bits 2:0 of the next read byte. A bit counter or bus state that slips shows within one byte: an ACK goes missing, or sda_oe is asserted on the wrong clock, so the master reads a shifted status byte. A commit that leaks early shows as chan_en changing before the STOP, in the same transaction as the write.

// File: rtl/chansel_pkg.sv
package chansel_pkg;
  localparam int unsigned N_CH   = 4;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WBYTE, S_WACK, S_RBYTE, S_RACK, S_SKIP
  } bus_st_t;

  // Channel enables from a stored selection: bit 2 gates, bits 1:0 index.
  function automatic logic [N_CH-1:0] sel_to_en(input logic [SEL_W-1:0] sel);
    logic [N_CH-1:0] en;
    en = '0;
    if (sel[2]) en[sel[1:0]] = 1'b1;
    return en;
  endfunction

  // Status byte: active interrupts high nibble, zero, stored selection.
  function automatic logic [BYTE_W-1:0] status_of(input logic [N_CH-1:0] irq_act,
                                                 input logic [SEL_W-1:0] sel);
    return {irq_act, 1'b0, sel};
  endfunction
endpackage

// File: rtl/chansel_sync.sv
module chansel_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic        RVAL   = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= {W{RVAL}};
      else if (i == 0) stg[i] <= d;
      else stg[i] <= stg[(i == 0) ? 0 : i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/chansel_cond.sv
module chansel_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_e,
  output logic stop_e,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign start_e  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_e   = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
endmodule

// File: rtl/chansel_fsm.sv
module chansel_fsm
  import chansel_pkg::*;
#(
  parameter logic [3:0] ADDR_HI = 4'b1110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             start_e,
  input  logic             stop_e,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic [2:0]       addr_pins,
  input  logic [N_CH-1:0]  irq_act,
  output bus_st_t          st,
  output logic [SEL_W-1:0] sel_q,
  output logic             sda_oe
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);

  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh, tx;
  logic [SEL_W-1:0]  pend;
  logic              pend_vld, mack;
  logic              byte_in, addr_hit;

  assign byte_in  = scl_fall && (cnt == CNT_W'(BYTE_W));
  assign addr_hit = (sh[7:1] == {ADDR_HI, addr_pins});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; tx <= '0;
      pend <= '0; pend_vld <= 1'b0; sel_q <= '0; mack <= 1'b0;
    end else if (stop_e) begin
      st <= S_IDLE;
      if (pend_vld) sel_q <= pend;
      pend_vld <= 1'b0;
    end else if (start_e) begin
      st  <= S_ADDR;
      cnt <= '0;
    end else begin
      case (st)
        S_ADDR: begin
          if (scl_rise) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (byte_in) st <= addr_hit ? S_AACK : S_SKIP;
        end
        S_AACK: if (scl_fall) begin
          cnt <= '0;
          if (sh[0]) begin
            tx <= status_of(irq_act, sel_q);
            st <= S_RBYTE;
          end else st <= S_WBYTE;
        end
        S_WBYTE: begin
          if (scl_rise) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (byte_in) begin
            pend     <= sh[SEL_W-1:0];
            pend_vld <= 1'b1;
            st       <= S_WACK;
          end
        end
        S_WACK: if (scl_fall) begin
          cnt <= '0;
          st  <= S_WBYTE;
        end
        S_RBYTE: if (scl_fall) begin
          if (cnt == CNT_W'(BYTE_W - 1)) st <= S_RACK;
          else begin
            tx  <= {tx[6:0], 1'b0};
            cnt <= cnt + 1'b1;
          end
        end
        S_RACK: begin
          if (scl_rise) mack <= ~sda_s;
          else if (scl_fall) begin
            if (mack) begin
              tx  <= status_of(irq_act, sel_q);
              cnt <= '0;
              st  <= S_RBYTE;
            end else st <= S_SKIP;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = (st == S_AACK) || (st == S_WACK) || ((st == S_RBYTE) && !tx[7]);
endmodule

// File: rtl/chansel_ctl.sv
module chansel_ctl
  import chansel_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [3:0]  ADDR_HI     = 4'b1110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] addr_pins,
  input  logic [3:0] irq_n,
  output logic [3:0] chan_en
);
  logic            scl_s, sda_s;
  logic [N_CH-1:0] irq_s;
  logic            start_w, stop_w, rise_w, fall_w;
  bus_st_t         st_w;
  logic [SEL_W-1:0] sel_w;

  chansel_sync #(.W(2), .STAGES(SYNC_STAGES), .RVAL(1'b1)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s}));

  chansel_sync #(.W(N_CH), .STAGES(SYNC_STAGES), .RVAL(1'b1)) u_irq_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_n), .q(irq_s));

  chansel_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .start_e(start_w), .stop_e(stop_w), .scl_rise(rise_w), .scl_fall(fall_w));

  chansel_fsm #(.ADDR_HI(ADDR_HI)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .start_e(start_w), .stop_e(stop_w), .scl_rise(rise_w), .scl_fall(fall_w),
    .addr_pins(addr_pins), .irq_act(~irq_s),
    .st(st_w), .sel_q(sel_w), .sda_oe(sda_oe));

  assign chan_en = sel_to_en(sel_w);
endmodule

// File: rtl/chansel_ctl_chk.sv
module chansel_ctl_chk
  import chansel_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic [3:0] chan_en,
  input logic       start_w,
  input logic       stop_w,
  input bus_st_t    st_w
);
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_en));

  p_hold_until_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_w |=> $stable(chan_en));

  p_start_rearms_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_w && !stop_w) |=> (st_w == S_ADDR));

  p_stop_releases_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_w |=> !sda_oe);

  p_skip_sticks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_w == S_SKIP && !start_w && !stop_w) |=> (st_w == S_SKIP));

  p_reset_clear_r6: assert property (@(posedge clk)
    !rst_n |=> (chan_en == 4'b0000 && !sda_oe));
endmodule

bind chansel_ctl chansel_ctl_chk u_chk (.*);

// File: tb/chansel_ctl_test.sv
module chansel_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, m_sda = 1'b1;
  logic [2:0] addr_pins = 3'd0;
  logic [3:0] irq_n = 4'hF;
  logic sda_oe;
  logic [3:0] chan_en;
  wire sda_line = m_sda & ~sda_oe;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chansel_ctl uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_pins(addr_pins), .irq_n(irq_n), .chan_en(chan_en));

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] en_of(input logic [7:0] b);
    return b[2] ? (4'b0001 << b[1:0]) : 4'b0000;
  endfunction

  task automatic i2c_start;
    m_sda = 1'b1; waitc(Q); scl = 1'b1; waitc(Q);
    m_sda = 1'b0; waitc(Q); scl = 1'b0; waitc(Q);
  endtask

  task automatic i2c_stop;
    m_sda = 1'b0; waitc(Q); scl = 1'b1; waitc(Q);
    m_sda = 1'b1; waitc(Q);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; waitc(Q); scl = 1'b1; waitc(Q); scl = 1'b0; waitc(Q);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; waitc(Q); scl = 1'b1; waitc(Q/2);
    b = sda_line; waitc(Q/2); scl = 1'b0; waitc(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic recv_bits(output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] rb, rb2, data;
    logic [3:0] exp_en;
    logic [2:0] cur_sel;

    waitc(5); rst_n = 1'b1; waitc(5);
    chk({4'b0, chan_en}, 8'h00, "R6 chan_en after reset");
    chk({7'b0, sda_oe}, 8'h00, "R6 sda_oe after reset");
    exp_en = 4'b0000; cur_sel = 3'd0;

    // Sweep strap pins and all selection codes.
    for (int p = 0; p < 8; p++) begin
      for (int v = 0; v < 8; v++) begin
        addr_pins = 3'(p);
        irq_n = ~4'(p*3 + v);
        data = {3'(p), 2'(v), 3'(v)};
        i2c_start;
        send_byte({4'b1110, 3'(p), 1'b0}, ack);
        chk({7'b0, ack}, 8'h01, "R5 address ack");
        send_byte(data, ack);
        chk({7'b0, ack}, 8'h01, "R11 data ack");
        chk({4'b0, chan_en}, {4'b0, exp_en}, "R3 held before stop");
        i2c_stop;
        exp_en = en_of(data); cur_sel = 3'(v);
        chk({4'b0, chan_en}, {4'b0, exp_en}, "R1 enables after stop");
        chk(8'($countones(chan_en) <= 1), 8'h01, "R2 one-hot");
        i2c_start;
        send_byte({4'b1110, 3'(p), 1'b1}, ack);
        chk({7'b0, ack}, 8'h01, "R5 read address ack");
        recv_bits(rb);
        put_bit(1'b1);
        i2c_stop;
        chk(rb, {~irq_n, 1'b0, cur_sel}, "R7 status byte");
      end
    end

    // R9: pin mismatch and upper-bit mismatch.
    addr_pins = 3'd5;
    i2c_start;
    send_byte({4'b1110, 3'd4, 1'b0}, ack);
    chk({7'b0, ack}, 8'h00, "R9 no ack on pin mismatch");
    send_byte(8'h04, ack);
    chk({7'b0, ack}, 8'h00, "R9 ignored byte not acked");
    i2c_stop;
    chk({4'b0, chan_en}, {4'b0, exp_en}, "R9 selection unchanged");
    i2c_start;
    send_byte({4'b1101, 3'd5, 1'b0}, ack);
    chk({7'b0, ack}, 8'h00, "R9 no ack on upper mismatch");
    send_byte(8'h05, ack);
    i2c_stop;
    chk({4'b0, chan_en}, {4'b0, exp_en}, "R9 selection unchanged upper");

    // R4: multi-byte write keeps the last byte.
    i2c_start;
    send_byte({4'b1110, 3'd5, 1'b0}, ack);
    send_byte(8'h05, ack);
    send_byte(8'h07, ack);
    send_byte(8'hF6, ack);
    chk({7'b0, ack}, 8'h01, "R11 third byte ack");
    chk({4'b0, chan_en}, {4'b0, exp_en}, "R3 held in multi-byte write");
    i2c_stop;
    exp_en = 4'b0100;
    chk({4'b0, chan_en}, {4'b0, exp_en}, "R4 last byte wins");

    // R8: STOP in the middle of a byte.
    i2c_start;
    send_byte({4'b1110, 3'd5, 1'b0}, ack);
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b0); put_bit(1'b0);
    put_bit(1'b0); put_bit(1'b1);
    i2c_stop;
    chk({4'b0, chan_en}, {4'b0, exp_en}, "R8 partial byte discarded");
    chk({7'b0, sda_oe}, 8'h00, "R8 sda released after abort");

    // R8: repeated START mid-byte, then a full write.
    i2c_start;
    send_byte({4'b1110, 3'd5, 1'b0}, ack);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    i2c_start;
    send_byte({4'b1110, 3'd5, 1'b0}, ack);
    chk({7'b0, ack}, 8'h01, "R8 address ack after restart");
    send_byte(8'h07, ack);
    i2c_stop;
    exp_en = 4'b1000;
    chk({4'b0, chan_en}, {4'b0, exp_en}, "R8 write after restart");

    // R10: ACK re-sends fresh status, NACK ends read.
    irq_n = 4'b1110;
    i2c_start;
    send_byte({4'b1110, 3'd5, 1'b1}, ack);
    recv_bits(rb);
    irq_n = 4'b0111;
    put_bit(1'b0);
    recv_bits(rb2);
    put_bit(1'b1);
    chk(rb, 8'b0001_0111, "R10 first read byte");
    chk(rb2, 8'b1000_0111, "R10 fresh byte after ack");
    waitc(Q);
    chk({7'b0, sda_oe}, 8'h00, "R10 released after nack");
    i2c_stop;
    chk({4'b0, chan_en}, {4'b0, exp_en}, "R10 read leaves selection");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule